// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the input levels of one eight-pin port before they reach the port's input register and its interrupt detector. Every pin passes through a two-stage synchronizer. A pin whose filter is switched on then moves its clean output to a new level only after the synchronized level has differed from that output for a programmed number of millisecond ticks. A pin whose filter is off follows the synchronized level with one register of delay.

All pins of the port share one hold-time register, counted in ticks of an external millisecond strobe, with a range of 0 to 255. Each pin has its own filter-enable bit. The enable bits are changed through a masked write, so software can switch some pins without touching the others. Each pin keeps its own tick counter. It also keeps its own copy of the hold time, taken when a counting interval opens, so a new hold time never shortens or stretches an interval that is already running.

Top module: `port_debounce`

## Requirements
- R1: After reset, `pad_clean`, `fen_q` and `hold_q` are all zero and no interval is running.
- R2: A cycle with `hold_we` high loads `hold_wdata` into the shared hold time, which is visible on `hold_q` after that clock edge.
- R3: A cycle with `fen_we` high updates only the enable bits whose mask bit in `fen_wdata[15:8]` is 1, setting each one to the matching bit of `fen_wdata[7:0]`. All other enable bits keep their value, and without `fen_we` no enable bit changes.
- R4: A pin whose enable bit is 0 shows a change of `pad_in` on `pad_clean` at the third rising clock edge after the change (two synchronizer stages, then the output register).
- R5: For a pin with its enable bit at 1 and a hold time N of 1 or more, an interval opens at the third edge after the input changes. A tick sampled at that opening edge is not counted. The output takes the new level at the edge that samples the N-th tick after that.
- R6: If the synchronized level returns to the clean level before N ticks have been counted, the output does not change. The next difference opens a fresh interval that counts from zero.
- R7: A pin with its enable bit at 1 and a hold time of 0 behaves exactly like a disabled pin, with the latency given in R4.
- R8: An interval in progress uses the hold time captured when it opened. A new value in the hold-time register applies from the next interval. While an interval runs, its tick counter stays below the captured hold time.
- R9: `pad_clean` only ever changes to the synchronized input level. On an enabled pin with an interval running, it changes only at an edge that samples `tick_ms` high.
- R10: Each pin counts ticks on its own. Two enabled pins whose intervals open at different times switch at different ticks, even though they share one hold time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | Single-cycle millisecond strobe |
| pad_in | input | NPINS | Raw asynchronous pin levels |
| hold_we | input | 1 | Write strobe for the shared hold time |
| hold_wdata | input | CNT_W | New hold time in ticks |
| fen_we | input | 1 | Masked write strobe for the enable bits |
| fen_wdata | input | 2*NPINS | Mask in the upper half, values in the lower half |
| pad_clean | output | NPINS | Filtered pin levels |
| fen_q | output | NPINS | Current per-pin filter enables |
| hold_q | output | CNT_W | Current shared hold time |

## Verification
The hardest case to reach from the ports is a hold-time write that lands inside an interval already under way. It can be seen only through the tick at which the output finally moves, not by reading any register. Directed sequences open an interval, let part of it run out, rewrite the hold time, and then count the ticks to the switch. Further directed sequences cover the restart after a short glitch and two pins whose intervals are staggered by one tick. A seeded random phase then mixes pin toggles, tick strobes, masked writes and hold-time changes, and compares every pin against a cycle model each cycle.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  // per-pin filter state
  typedef enum logic {
    PS_STABLE = 1'b0,
    PS_TIMING = 1'b1
  } pin_st_e;
endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pdb_cfg.sv
module pdb_cfg #(
  parameter int NPINS = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_we,
  input  logic [CNT_W-1:0] hold_wdata,
  input  logic             fen_we,
  input  logic [NPINS-1:0] fen_mask,
  input  logic [NPINS-1:0] fen_val,
  output logic [CNT_W-1:0] hold_q,
  output logic [NPINS-1:0] fen_q
);
  logic [CNT_W-1:0] hold_d;
  logic [NPINS-1:0] fen_d;

  always_comb begin
    hold_d = hold_q;
    fen_d  = fen_q;
    if (hold_we) hold_d = hold_wdata;
    if (fen_we)  fen_d  = (fen_q & ~fen_mask) | (fen_val & fen_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      fen_q  <= '0;
    end else begin
      hold_q <= hold_d;
      fen_q  <= fen_d;
    end
  end
endmodule

// File: rtl/pdb_pin.sv
module pdb_pin
  import pdb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] hold,
  input  logic             lvl,
  output logic             clean,
  output logic             timing,
  output logic [CNT_W-1:0] ctr,
  output logic [CNT_W-1:0] lim
);
  pin_st_e          st_q, st_d;
  logic [CNT_W-1:0] ctr_q, ctr_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             cln_q, cln_d;
  logic             differ;
  logic             last_tick;

  assign differ    = lvl ^ cln_q;
  assign last_tick = (ctr_q == lim_q - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    ctr_d = ctr_q;
    lim_d = lim_q;
    cln_d = cln_q;
    if (!en) begin
      st_d  = PS_STABLE;
      ctr_d = '0;
      cln_d = lvl;
    end else if (!differ) begin
      st_d  = PS_STABLE;
      ctr_d = '0;
    end else if (st_q == PS_STABLE) begin
      if (hold == '0) begin
        cln_d = lvl;
      end else begin
        st_d  = PS_TIMING;
        lim_d = hold;
        ctr_d = '0;
      end
    end else if (tick) begin
      if (last_tick) begin
        cln_d = lvl;
        st_d  = PS_STABLE;
        ctr_d = '0;
      end else begin
        ctr_d = ctr_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_STABLE;
      ctr_q <= '0;
      lim_q <= '0;
      cln_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ctr_q <= ctr_d;
      lim_q <= lim_d;
      cln_q <= cln_d;
    end
  end

  assign clean  = cln_q;
  assign timing = (st_q == PS_TIMING);
  assign ctr    = ctr_q;
  assign lim    = lim_q;
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
  parameter int NPINS       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic [NPINS-1:0]   pad_in,
  input  logic               hold_we,
  input  logic [CNT_W-1:0]   hold_wdata,
  input  logic               fen_we,
  input  logic [2*NPINS-1:0] fen_wdata,
  output logic [NPINS-1:0]   pad_clean,
  output logic [NPINS-1:0]   fen_q,
  output logic [CNT_W-1:0]   hold_q
);
  localparam int MSK_LO = NPINS;
  localparam int MSK_HI = 2*NPINS-1;

  logic [NPINS-1:0]            sync_w;
  logic [NPINS-1:0]            tim_w;
  logic [NPINS-1:0][CNT_W-1:0] ctr_w;
  logic [NPINS-1:0][CNT_W-1:0] lim_w;

  pdb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst_n (rst_n),
    .d (pad_in),
    .q (sync_w)
  );

  pdb_cfg #(.NPINS(NPINS), .CNT_W(CNT_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_we    (hold_we),
    .hold_wdata (hold_wdata),
    .fen_we     (fen_we),
    .fen_mask   (fen_wdata[MSK_HI:MSK_LO]),
    .fen_val    (fen_wdata[NPINS-1:0]),
    .hold_q     (hold_q),
    .fen_q      (fen_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pdb_pin #(.CNT_W(CNT_W)) pin_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_ms),
      .en     (fen_q[p]),
      .hold   (hold_q),
      .lvl    (sync_w[p]),
      .clean  (pad_clean[p]),
      .timing (tim_w[p]),
      .ctr    (ctr_w[p]),
      .lim    (lim_w[p])
    );
  end
endmodule

// File: rtl/pdb_chk.sv
module pdb_chk #(
  parameter int NPINS = 8,
  parameter int CNT_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_ms,
  input logic                        fen_we,
  input logic [2*NPINS-1:0]          fen_wdata,
  input logic [NPINS-1:0]            fen_q,
  input logic [NPINS-1:0]            sync_w,
  input logic [NPINS-1:0]            pad_clean,
  input logic [NPINS-1:0]            tim_w,
  input logic [NPINS-1:0][CNT_W-1:0] ctr_w,
  input logic [NPINS-1:0][CNT_W-1:0] lim_w
);
  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fen_we |=> ((fen_q ^ $past(fen_q)) & ~$past(fen_wdata[2*NPINS-1:NPINS])) == '0);

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fen_we |=> $stable(fen_q));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R4
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fen_q[i]) |-> pad_clean[i] == $past(sync_w[i]));

    // R9
    clean_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_clean[i] != $past(pad_clean[i])) |-> pad_clean[i] == $past(sync_w[i]));

    // R9
    tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tim_w[i]) && $past(fen_q[i]) && pad_clean[i] != $past(pad_clean[i]))
        |-> $past(tick_ms));

    // R8
    ctr_below_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tim_w[i] |-> ctr_w[i] < lim_w[i]);

    // R8
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tim_w[i]) && tim_w[i]) |-> $stable(lim_w[i]));
  end
endmodule

bind port_debounce pdb_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_ms   (tick_ms),
  .fen_we    (fen_we),
  .fen_wdata (fen_wdata),
  .fen_q     (fen_q),
  .sync_w    (sync_w),
  .pad_clean (pad_clean),
  .tim_w     (tim_w),
  .ctr_w     (ctr_w),
  .lim_w     (lim_w)
);

// File: tb/port_debounce_tb_top.sv
module port_debounce_tb_top;
  localparam int N = 8;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic           tick_ms;
  logic [N-1:0]   pad_in;
  logic           hold_we;
  logic [W-1:0]   hold_wdata;
  logic           fen_we;
  logic [2*N-1:0] fen_wdata;
  logic [N-1:0]   pad_clean;
  logic [N-1:0]   fen_q;
  logic [W-1:0]   hold_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  port_debounce #(.NPINS(N), .CNT_W(W)) dut_i (
    .clk (clk), .rst_n (rst_n), .tick_ms (tick_ms), .pad_in (pad_in),
    .hold_we (hold_we), .hold_wdata (hold_wdata),
    .fen_we (fen_we), .fen_wdata (fen_wdata),
    .pad_clean (pad_clean), .fen_q (fen_q), .hold_q (hold_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // cycle model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_clean, m_en;
  logic [W-1:0] m_hold;
  int  m_ctr [N];
  int  m_lim [N];
  bit  m_run [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_clean = '0; m_en = '0; m_hold = '0;
      for (int i = 0; i < N; i++) begin m_ctr[i] = 0; m_lim[i] = 0; m_run[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!m_en[i]) begin
          m_clean[i] = m_s2[i]; m_run[i] = 0;
        end else if (m_s2[i] == m_clean[i]) begin
          m_run[i] = 0;
        end else if (!m_run[i]) begin
          if (m_hold == 0) m_clean[i] = m_s2[i];
          else begin m_run[i] = 1; m_lim[i] = int'(m_hold); m_ctr[i] = 0; end
        end else if (tick_ms) begin
          m_ctr[i]++;
          if (m_ctr[i] >= m_lim[i]) begin m_clean[i] = m_s2[i]; m_run[i] = 0; end
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (hold_we) m_hold = hold_wdata;
      if (fen_we) m_en = (m_en & ~fen_wdata[2*N-1:N]) | (fen_wdata[N-1:0] & fen_wdata[2*N-1:N]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    tick_ms = 1'b1; step(1); tick_ms = 1'b0;
  endtask

  task automatic hold_write(input logic [W-1:0] v);
    hold_we = 1'b1; hold_wdata = v; step(1); hold_we = 1'b0;
  endtask

  task automatic en_write(input logic [2*N-1:0] v);
    fen_we = 1'b1; fen_wdata = v; step(1); fen_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; pad_in = '0;
    hold_we = 1'b0; hold_wdata = '0; fen_we = 1'b0; fen_wdata = '0;
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 clean", pad_clean, 0);
    chk("R1 enables", fen_q, 0);
    chk("R1 hold", hold_q, 0);

    en_write(16'hFF_A5);
    chk("R3 full write", fen_q, 8'hA5);
    en_write(16'h0F_0A);
    chk("R3 masked write", fen_q, 8'hAA);
    en_write(16'hFF_00);
    hold_write(8'd3);
    chk("R2 hold load", hold_q, 3);

    pad_in[0] = 1'b1;
    step(2); chk("R4 bypass early", pad_clean[0], 0);
    step(1); chk("R4 bypass third edge", pad_clean[0], 1);

    en_write(16'hFF_02);
    pad_in[1] = 1'b1; step(3);
    tick(); tick();
    chk("R5 before Nth tick", pad_clean[1], 0);
    tick();
    chk("R5 at Nth tick", pad_clean[1], 1);

    pad_in[1] = 1'b0; step(3);
    tick(); tick();
    pad_in[1] = 1'b1; step(3);
    chk("R6 glitch ignored", pad_clean[1], 1);
    pad_in[1] = 1'b0; step(3);
    tick(); tick();
    chk("R6 restart from zero", pad_clean[1], 1);
    tick();
    chk("R6 switch after full count", pad_clean[1], 0);

    hold_write(8'd0);
    pad_in[1] = 1'b1;
    step(2); chk("R7 zero hold early", pad_clean[1], 0);
    step(1); chk("R7 zero hold third edge", pad_clean[1], 1);

    hold_write(8'd4);
    pad_in[1] = 1'b0; step(3);
    tick();
    hold_write(8'd1);
    tick(); tick();
    chk("R8 captured hold kept", pad_clean[1], 1);
    tick();
    chk("R8 switch at captured count", pad_clean[1], 0);
    pad_in[1] = 1'b1; step(3);
    tick();
    chk("R8 new hold next interval", pad_clean[1], 1);

    hold_write(8'd2);
    en_write(16'hFF_18);
    pad_in[3] = 1'b1; step(3);
    tick();
    pad_in[4] = 1'b1; step(3);
    tick();
    chk("R10 staggered first", pad_clean[4:3], 2'b01);
    tick();
    chk("R10 staggered second", pad_clean[4:3], 2'b11);

    chk("R4 model aligned", pad_clean, m_clean);

    for (int c = 0; c < 4000; c++) begin
      tick_ms = (($urandom % 4) == 0);
      hold_we = 1'b0; fen_we = 1'b0;
      if (($urandom % 8) == 0) pad_in[$urandom % N] ^= 1'b1;
      if (($urandom % 50) == 0) begin hold_we = 1'b1; hold_wdata = W'($urandom % 6); end
      if (($urandom % 60) == 0) begin fen_we = 1'b1; fen_wdata = 16'($urandom); end
      step(1);
      chk("R5 R6 R9 random clean", pad_clean, m_clean);
      if ((c % 16) == 0) begin
        chk("R3 random enables", fen_q, m_en);
        chk("R2 random hold", hold_q, m_hold);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule